// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block sits between instruction decode and the load/store path of a processor core. For each accepted request it takes a decoded addressing-mode code, the contents of a base register and an index register, a constant from the instruction word, an access size and a scale selector. It returns either an operand value (register and immediate forms) or a memory address. A flag marks which of the two the result is. A single-cycle done strobe shows that the result is valid.

Nine addressing modes are covered, together with a separate pre-decrement form of the auto-step mode. All modes except memory-indirect finish in the cycle after the request. Memory-indirect uses a read request/response port to fetch a pointer from the address held in the base register. The returned word becomes the final address, and the unit stays busy until that response arrives. The two auto-step forms also return an updated base value with a write-back enable, for the register file to commit.

Top module: `oag_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `done`, `busy`, `mem_rd_req` and `base_wb_en` are all 0.
- R2: Mode code 0 (register) returns `base_val` and mode code 1 (immediate) returns `const_val`. In both, `result_is_addr`=0 and `done` is 1 in the cycle after an accepted request, with no memory read.
- R3: Mode code 2 (register indirect) returns the address `base_val`. Mode code 5 (direct) returns the address `const_val`. Both have `result_is_addr`=1.
- R4: Mode code 3 (displacement) returns `base_val + const_val`. Mode code 4 (indexed) returns `base_val + index_val`. Both sums wrap modulo 2^DW.
- R5: Mode code 9 (scaled) returns `const_val + base_val + (index_val << req_scale)`. A `req_scale` value of 0..3 selects a factor of 1, 2, 4 or 8.
- R6: Mode code 7 (post-increment) returns the address `base_val` with `base_wb_en`=1 and `base_wb_val = base_val + (1 << req_size)`. A `req_size` value of 0..3 selects a step of 1, 2, 4 or 8 bytes, and the sum wraps.
- R7: Mode code 8 (pre-decrement) returns the address `base_val - (1 << req_size)`, with `base_wb_en`=1 and `base_wb_val` equal to that same address.
- R8: Mode code 6 (memory indirect) raises `mem_rd_req` with `mem_rd_addr = base_val` in the cycle after acceptance. Both hold steady until a cycle with `mem_rd_ack`=1. In the next cycle `done`=1, `result` equals the `mem_rd_data` sampled with the ack, and `result_is_addr`=1.
- R9: A request is accepted only when `req_valid`=1 and `busy`=0. `busy` is 1 from the cycle after a memory-indirect acceptance through the ack cycle. A request presented while busy, including in the ack cycle, produces no result.
- R10: `done` and `base_wb_en` are single-cycle pulses. `base_wb_en` is 1 only together with `done` for mode codes 7 and 8.
- R11: Mode codes 10 to 15 are reserved. They behave as register mode: `result = base_val`, `result_is_addr`=0, done after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 4 | Addressing-mode code |
| req_size | input | 2 | log2 of access size in bytes |
| req_scale | input | 2 | log2 of index scale factor |
| base_val | input | DW | Base register contents |
| index_val | input | DW | Index register contents |
| const_val | input | DW | Instruction constant |
| busy | output | 1 | Memory-indirect fetch in progress |
| done | output | 1 | Result valid pulse |
| result | output | DW | Operand value or address |
| result_is_addr | output | 1 | 1 when result is a memory address |
| base_wb_en | output | 1 | Base register write-back enable |
| base_wb_val | output | DW | Updated base value |
| mem_rd_req | output | 1 | Pointer read request |
| mem_rd_addr | output | DW | Pointer read address |
| mem_rd_ack | input | 1 | Pointer read response valid |
| mem_rd_data | input | DW | Pointer read response data |

## Verification
The functions that can fall in the same cycle are the memory response completing a pending indirect fetch and a fresh request arriving at the input. The bench starts an indirect fetch and withholds the ack for several cycles while presenting a register-mode request. It then presents another request in the very cycle the ack arrives. The check is that only the fetched pointer emerges with `done`, that the read address stays steady while waiting, and that no further done pulse follows.

// File: rtl/oag_pkg.sv
package oag_pkg;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_SEL  = 1 << SEL_W;

  typedef enum logic [MODE_W-1:0] {
    AM_REG    = 4'd0,
    AM_IMM    = 4'd1,
    AM_RIND   = 4'd2,
    AM_DISP   = 4'd3,
    AM_IDX    = 4'd4,
    AM_DIR    = 4'd5,
    AM_MIND   = 4'd6,
    AM_PINC   = 4'd7,
    AM_PDEC   = 4'd8,
    AM_SCALED = 4'd9
  } amode_e;
endpackage

// File: rtl/oag_calc.sv
module oag_calc
  import oag_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  size_sel,
  input  logic [SEL_W-1:0]  scale_sel,
  input  logic [DW-1:0]     base,
  input  logic [DW-1:0]     index,
  input  logic [DW-1:0]     cval,
  output logic [DW-1:0]     res,
  output logic              res_is_addr,
  output logic              wb_en,
  output logic [DW-1:0]     wb_val,
  output logic              is_indirect
);
  logic [DW-1:0] idx_shl  [N_SEL];
  logic [DW-1:0] step_tab [N_SEL];

  for (genvar k = 0; k < N_SEL; k++) begin : g_sel
    assign idx_shl[k]  = index << k;
    assign step_tab[k] = DW'(1) << k;
  end

  logic [DW-1:0] idx_scaled;
  logic [DW-1:0] step;
  logic [DW-1:0] base_dec;
  assign idx_scaled = idx_shl[scale_sel];
  assign step       = step_tab[size_sel];
  assign base_dec   = base - step;

  always_comb begin
    res         = base;
    res_is_addr = 1'b0;
    wb_en       = 1'b0;
    wb_val      = base;
    is_indirect = 1'b0;
    case (mode)
      AM_REG:    begin res = base; res_is_addr = 1'b0; end
      AM_IMM:    begin res = cval; res_is_addr = 1'b0; end
      AM_RIND:   begin res = base; res_is_addr = 1'b1; end
      AM_DISP:   begin res = base + cval; res_is_addr = 1'b1; end
      AM_IDX:    begin res = base + index; res_is_addr = 1'b1; end
      AM_DIR:    begin res = cval; res_is_addr = 1'b1; end
      AM_MIND:   begin res = base; res_is_addr = 1'b1; is_indirect = 1'b1; end
      AM_PINC:   begin
        res = base; res_is_addr = 1'b1; wb_en = 1'b1; wb_val = base + step;
      end
      AM_PDEC:   begin
        res = base_dec; res_is_addr = 1'b1; wb_en = 1'b1; wb_val = base_dec;
      end
      AM_SCALED: begin res = cval + base + idx_scaled; res_is_addr = 1'b1; end
      default:   begin res = base; res_is_addr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/oag_ind_fsm.sv
module oag_ind_fsm #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] start_addr,
  input  logic          mem_rd_ack,
  input  logic [DW-1:0] mem_rd_data,
  output logic          busy,
  output logic          mem_rd_req,
  output logic [DW-1:0] mem_rd_addr,
  output logic          fin,
  output logic [DW-1:0] fin_data
);
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;

  st_e           st_q, st_d;
  logic [DW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    st_d    = st_q;
    addr_en = 1'b0;
    addr_d  = start_addr;
    case (st_q)
      ST_IDLE: if (start) begin st_d = ST_WAIT; addr_en = 1'b1; end
      ST_WAIT: if (mem_rd_ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign busy        = (st_q == ST_WAIT);
  assign mem_rd_req  = (st_q == ST_WAIT);
  assign mem_rd_addr = addr_q;
  assign fin         = (st_q == ST_WAIT) && mem_rd_ack;
  assign fin_data    = mem_rd_data;
endmodule

// File: rtl/oag_top.sv
module oag_top
  import oag_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [SEL_W-1:0]  req_size,
  input  logic [SEL_W-1:0]  req_scale,
  input  logic [DW-1:0]     base_val,
  input  logic [DW-1:0]     index_val,
  input  logic [DW-1:0]     const_val,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     result,
  output logic              result_is_addr,
  output logic              base_wb_en,
  output logic [DW-1:0]     base_wb_val,
  output logic              mem_rd_req,
  output logic [DW-1:0]     mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DW-1:0]     mem_rd_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DW-1:0] c_res, c_wb_val;
  logic          c_is_addr, c_wb_en, c_ind;

  oag_calc #(.DW(DW)) calc_i (
    .mode        (req_mode),
    .size_sel    (req_size),
    .scale_sel   (req_scale),
    .base        (base_val),
    .index       (index_val),
    .cval        (const_val),
    .res         (c_res),
    .res_is_addr (c_is_addr),
    .wb_en       (c_wb_en),
    .wb_val      (c_wb_val),
    .is_indirect (c_ind)
  );

  logic          accept, ind_start, fin;
  logic [DW-1:0] fin_data;
  logic          fsm_busy;

  assign accept    = req_valid && !fsm_busy && rst_int_n;
  assign ind_start = accept && c_ind;

  oag_ind_fsm #(.DW(DW)) ind_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (ind_start),
    .start_addr  (base_val),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data),
    .busy        (fsm_busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .fin         (fin),
    .fin_data    (fin_data)
  );

  logic          done_q, done_d;
  logic          wb_en_q, wb_en_d;
  logic [DW-1:0] res_q, res_d, wbv_q, wbv_d;
  logic          isa_q, isa_d;
  logic          out_en;

  always_comb begin
    done_d  = (accept && !c_ind) || fin;
    wb_en_d = accept && !c_ind && c_wb_en;
    out_en  = done_d;
    if (fin) begin
      res_d = fin_data;
      isa_d = 1'b1;
    end else begin
      res_d = c_res;
      isa_d = c_is_addr;
    end
    wbv_d = c_wb_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
    end else if (!rst_int_n) begin
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      wb_en_q <= wb_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      isa_q <= 1'b0;
      wbv_q <= '0;
    end else if (out_en) begin
      res_q <= res_d;
      isa_q <= isa_d;
      wbv_q <= wbv_d;
    end
  end

  assign busy           = fsm_busy;
  assign done           = done_q;
  assign result         = res_q;
  assign result_is_addr = isa_q;
  assign base_wb_en     = wb_en_q;
  assign base_wb_val    = wbv_q;
endmodule

// File: rtl/oag_checker.sv
module oag_checker
  import oag_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [MODE_W-1:0] req_mode,
  input logic              busy,
  input logic              done,
  input logic              result_is_addr,
  input logic              base_wb_en,
  input logic              mem_rd_req,
  input logic [DW-1:0]     mem_rd_addr,
  input logic              mem_rd_ack
);
  logic up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R8

  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_ack) |=> (done && result_is_addr && !busy)); // R8

  AST_SIMPLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && req_valid && !busy && req_mode != AM_MIND) |=> done); // R2

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rd_ack) |=> !done); // R9

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    base_wb_en |-> done); // R10

  AST_DONE_PULSE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    base_wb_en |=> !base_wb_en || done); // R10
endmodule

bind oag_top oag_checker #(.DW(DW)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_mode       (req_mode),
  .busy           (busy),
  .done           (done),
  .result_is_addr (result_is_addr),
  .base_wb_en     (base_wb_en),
  .mem_rd_req     (mem_rd_req),
  .mem_rd_addr    (mem_rd_addr),
  .mem_rd_ack     (mem_rd_ack)
);

// File: tb/oag_top_tb_top.sv
module oag_top_tb_top;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [3:0]    req_mode = '0;
  logic [1:0]    req_size = '0;
  logic [1:0]    req_scale = '0;
  logic [DW-1:0] base_val = '0, index_val = '0, const_val = '0;
  logic          mem_rd_ack = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic          busy, done, result_is_addr, base_wb_en, mem_rd_req;
  logic [DW-1:0] result, base_wb_val, mem_rd_addr;

  always #10 clk = ~clk;

  oag_top #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_size(req_size), .req_scale(req_scale), .base_val(base_val),
    .index_val(index_val), .const_val(const_val), .busy(busy), .done(done),
    .result(result), .result_is_addr(result_is_addr), .base_wb_en(base_wb_en),
    .base_wb_val(base_wb_val), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]    mode;
    logic [1:0]    size;
    logic [1:0]    scale;
    logic [31:0]   base;
    logic [31:0]   index;
    logic [31:0]   cval;
    logic [31:0]   exp_res;
    logic          exp_addr;
    logic          exp_wb;
    logic [31:0]   exp_wbv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 2'd0, 2'd0, 32'h1234_5678, 32'h0, 32'h0, 32'h1234_5678, 1'b0, 1'b0, 32'h0},        // R2
    '{4'd1, 2'd0, 2'd0, 32'h0, 32'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0},        // R2
    '{4'd2, 2'd0, 2'd0, 32'h0000_1000, 32'h0, 32'h0, 32'h0000_1000, 1'b1, 1'b0, 32'h0},        // R3
    '{4'd5, 2'd0, 2'd0, 32'h0, 32'h0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 32'h0},        // R3
    '{4'd3, 2'd0, 2'd0, 32'h0000_1000, 32'h0, 32'h20, 32'h0000_1020, 1'b1, 1'b0, 32'h0},       // R4
    '{4'd3, 2'd0, 2'd0, 32'h10, 32'h0, 32'hFFFF_FFF0, 32'h0, 1'b1, 1'b0, 32'h0},               // R4
    '{4'd4, 2'd0, 2'd0, 32'h2000, 32'h30, 32'h0, 32'h2030, 1'b1, 1'b0, 32'h0},                 // R4
    '{4'd9, 2'd0, 2'd3, 32'h1000, 32'h5, 32'h100, 32'h1128, 1'b1, 1'b0, 32'h0},                // R5
    '{4'd9, 2'd0, 2'd0, 32'h2, 32'h3, 32'h1, 32'h6, 1'b1, 1'b0, 32'h0},                        // R5
    '{4'd7, 2'd2, 2'd0, 32'h400, 32'h0, 32'h0, 32'h400, 1'b1, 1'b1, 32'h404},                  // R6
    '{4'd7, 2'd3, 2'd0, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b1, 1'b1, 32'h4},        // R6
    '{4'd8, 2'd0, 2'd0, 32'h400, 32'h0, 32'h0, 32'h3FF, 1'b1, 1'b1, 32'h3FF},                  // R7
    '{4'd8, 2'd1, 2'd0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFE, 1'b1, 1'b1, 32'hFFFF_FFFE},        // R7
    '{4'd12, 2'd0, 2'd0, 32'h77, 32'h0, 32'h0, 32'h77, 1'b0, 1'b0, 32'h0}                      // R11
  };

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1:       return "R2";
      4'd2, 4'd5:       return "R3";
      4'd3, 4'd4:       return "R4";
      4'd9:             return "R5";
      4'd7:             return "R6";
      4'd8:             return "R7";
      default:          return "R11";
    endcase
  endfunction

  task automatic drive(input logic [3:0] m, input logic [1:0] sz, input logic [1:0] sc,
                       input logic [31:0] b, input logic [31:0] ix, input logic [31:0] c);
    req_valid = 1'b1; req_mode = m; req_size = sz; req_scale = sc;
    base_val = b; index_val = ix; const_val = c;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "mem_rd_req", 32'(mem_rd_req), 32'd0);
    chk("R1", "base_wb_en", 32'(base_wb_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after release", 32'(done), 32'd0);
    repeat (4) @(negedge clk);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].mode, VEC[i].size, VEC[i].scale, VEC[i].base, VEC[i].index, VEC[i].cval);
      @(negedge clk);
      req_valid = 1'b0;
      chk(tag_of(VEC[i].mode), "done", 32'(done), 32'd1);
      chk(tag_of(VEC[i].mode), "result", result, VEC[i].exp_res);
      chk(tag_of(VEC[i].mode), "is_addr", 32'(result_is_addr), 32'(VEC[i].exp_addr));
      chk("R10", "wb_en", 32'(base_wb_en), 32'(VEC[i].exp_wb));
      if (VEC[i].exp_wb) chk(tag_of(VEC[i].mode), "wb_val", base_wb_val, VEC[i].exp_wbv);
      chk("R2", "no mem read", 32'(mem_rd_req), 32'd0);
      @(negedge clk);
      chk("R10", "done pulse", 32'(done), 32'd0);
      chk("R10", "wb pulse", 32'(base_wb_en), 32'd0);
    end

    // back-to-back simple requests
    drive(4'd1, 2'd0, 2'd0, 32'h0, 32'h0, 32'h11);
    @(negedge clk);
    chk("R2", "b2b first", result, 32'h11);
    drive(4'd4, 2'd0, 2'd0, 32'h5, 32'h6, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4", "b2b second done", 32'(done), 32'd1);
    chk("R4", "b2b second", result, 32'hB);
    @(negedge clk);

    // R8 / R9: memory-indirect with delayed ack and competing requests
    drive(4'd6, 2'd0, 2'd0, 32'h0000_5000, 32'h0, 32'h0);
    @(negedge clk);
    drive(4'd0, 2'd0, 2'd0, 32'h0000_0009, 32'h0, 32'h0);
    chk("R8", "mem_rd_req", 32'(mem_rd_req), 32'd1);
    chk("R8", "mem_rd_addr", mem_rd_addr, 32'h0000_5000);
    chk("R9", "busy", 32'(busy), 32'd1);
    chk("R8", "no early done", 32'(done), 32'd0);
    @(negedge clk);
    chk("R9", "no done while busy", 32'(done), 32'd0);
    chk("R8", "addr held", mem_rd_addr, 32'h0000_5000);
    @(negedge clk);
    chk("R9", "still no done", 32'(done), 32'd0);
    mem_rd_ack = 1'b1; mem_rd_data = 32'hABCD_0000;
    drive(4'd1, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0000_0042);
    @(negedge clk);
    mem_rd_ack = 1'b0; req_valid = 1'b0;
    chk("R8", "done after ack", 32'(done), 32'd1);
    chk("R8", "pointer result", result, 32'hABCD_0000);
    chk("R8", "is_addr", 32'(result_is_addr), 32'd1);
    chk("R8", "req dropped", 32'(mem_rd_req), 32'd0);
    chk("R9", "busy cleared", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R9", "ack-cycle request ignored", 32'(done), 32'd0);
    chk("R9", "result kept", result, 32'hABCD_0000);

    // R1: reset in the middle of an indirect fetch
    drive(4'd6, 2'd0, 2'd0, 32'h0000_6000, 32'h0, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", "reset clears req", 32'(mem_rd_req), 32'd0);
    chk("R1", "reset clears busy", 32'(busy), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after reset", 32'(done), 32'd0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule